// File: doc/BRIEF.md
# Reference-Clock Bring-Up Sequencer

This block takes one root-port link from cold reset to link training without software help. A start pulse launches it. It first waits for the PHY to report that the reference clock is present. It then opens a lane configuration window and runs two ordered request/acknowledge exchanges with the lane. Once both are granted, it turns on the lane and port reference clocks while the fundamental reset is still held. After a minimum hold time it releases that reset. It lets the link settle for a fixed time before it looks at the port-ready status. When the port reports ready, it lifts the clock-gating disables on both clocks and fires a one-cycle link-training start.

Every wait and delay counts clock cycles, and a single shared counter serves all of them. The cycle counts come from a clock-frequency parameter in kHz and from durations given in microseconds. Any wait that runs out ends the sequence with a sticky timeout flag. A sequence that completes ends with a sticky done flag. Both flags stay set until the next start pulse, and a start pulse that arrives mid-sequence is ignored.

Top module: `refclk_bringup_seq`

## Requirements
- R1: While reset is applied, and after it, every output is low except the two clock-gating disables, which are high. The fundamental-reset control is therefore low, meaning the port is held in reset.
- R2: A start pulse accepted while idle, done or timed out raises the application clock enable one cycle later and begins waiting for the PHY reference clock. No lane request is made before that status is seen. If it is not seen within the handshake limit, which is HS_CYC cycles in the wait state, the timeout flag is raised.
- R3: The config-access enable and request 0 rise together on the cycle after the PHY status is sampled high. Request 1 rises only on the cycle after acknowledge 0 is sampled high. If either acknowledge is missing for HS_CYC cycles, the sequence times out and config-access drops.
- R4: On the cycle after acknowledge 1 is sampled, config-access drops. On that same cycle both lane reference-clock enable bits (value 2'b11) and the port reference-clock enable rise.
- R5: The fundamental-reset control goes high exactly PERST_CYC cycles after the clock enables rise.
- R6: Port ready is ignored for SETTLE_CYC cycles after reset release. After that it is polled for up to READY_CYC cycles, and if it is still absent the timeout flag is raised.
- R7: On the cycle after ready is sampled, both clock-gating disables drop. One cycle later the link-training start is high for exactly one cycle, and done rises on that same cycle.
- R8: Done and timeout are never high together. Each stays set until the next accepted start pulse, which clears it one cycle after the pulse.
- R9: A start pulse during a running sequence has no effect on any output or on the timing of the sequence.
- R10: Each duration in cycles is ceil(CLK_KHZ × microseconds / 1000), with a minimum of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| phy_refclk_ok_i | input | 1 | PHY reports the reference clock present |
| lane_ack0_i | input | 1 | Lane acknowledge for request 0 |
| lane_ack1_i | input | 1 | Lane acknowledge for request 1 |
| port_ready_i | input | 1 | Port reports ready after reset release |
| app_clk_en_o | output | 1 | Application clock enable |
| cfg_access_o | output | 1 | Lane configuration-access window |
| lane_req0_o | output | 1 | Lane clock request 0 |
| lane_req1_o | output | 1 | Lane clock request 1 |
| lane_refclk_en_o | output | 2 | Lane reference-clock enables |
| port_refclk_en_o | output | 1 | Port reference-clock enable |
| refclk_gate_dis_o | output | 1 | Reference-clock gating disable |
| appclk_gate_dis_o | output | 1 | Application-clock gating disable |
| perst_n_o | output | 1 | Fundamental reset control, low holds the port in reset |
| ltssm_start_o | output | 1 | One-cycle link-training start |
| done_o | output | 1 | Sticky: sequence completed |
| timeout_o | output | 1 | Sticky: a wait expired |

## Verification
The bench drives the sequence along its nominal path with port ready already high during the settle time. Here an early ungating step would show that ready was sampled too soon. It also runs a path where ready arrives well after polling starts, which separates the settle delay from the poll response. Separate runs withhold the PHY status, acknowledge 0, acknowledge 1 and port ready in turn, so that each timeout is tied to its own wait state and its exact expiry cycle. A start pulse injected mid-run, together with restarts from both the done and the timeout state, covers the sticky flags and the ignored-while-busy rule.

// File: rtl/rcs_pkg.sv
// Shared definitions for the reference-clock bring-up sequencer.
// Assumes durations fit in 64-bit products of kHz and microseconds.
package rcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PHY,
        ST_REQ0,
        ST_REQ1,
        ST_HOLD,
        ST_SETTLE,
        ST_POLL,
        ST_KICK,
        ST_DONE,
        ST_FAIL
    } rcs_state_e;

    // Converts a duration in microseconds into clock cycles, rounding up, never below one.
    function automatic int unsigned us_to_cyc(input longint unsigned khz, input longint unsigned us);
        longint unsigned c;
        c = (khz * us + 64'd999) / 64'd1000;
        if (c < 64'd1) c = 64'd1;
        return int'(c);
    endfunction

    // Largest of four cycle counts.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/rcs_cycle_timer.sv
// Shared cycle counter: restarts from zero on clear, otherwise counts up and
// saturates at its all-ones value. Assumes the owner clears it on each state entry.
module rcs_cycle_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] TOP = '1;

    // Count elapsed cycles in the current state.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            count_o <= '0;
        end else if (count_o != TOP) begin
            count_o <= count_o + 1'b1;
        end
    end

endmodule

// File: rtl/rcs_bringup_fsm.sv
// Bring-up control: steps through PHY wait, two lane handshakes, clock enable,
// reset hold, settle and ready poll, and drives every output from registers
// that change on the same edge as the state. Assumes count_i is zero on the
// first cycle in each state (timer cleared on every transition).
module rcs_bringup_fsm
    import rcs_pkg::*;
#(
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned HS_CYC     = 4,
    parameter int unsigned PERST_CYC  = 4,
    parameter int unsigned SETTLE_CYC = 4,
    parameter int unsigned READY_CYC  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             phy_ok_i,
    input  logic             ack0_i,
    input  logic             ack1_i,
    input  logic             ready_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             tmr_clr_o,
    output logic             app_en_o,
    output logic             cfg_o,
    output logic             req0_o,
    output logic             req1_o,
    output logic [1:0]       lane_en_o,
    output logic             port_en_o,
    output logic             gate_dis_o,
    output logic             perst_n_o,
    output logic             kick_o,
    output logic             done_o,
    output logic             fail_o
);

    localparam logic [CNT_W-1:0] HS_LAST     = CNT_W'(HS_CYC - 1);
    localparam logic [CNT_W-1:0] PERST_LAST  = CNT_W'(PERST_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] READY_LAST  = CNT_W'(READY_CYC - 1);

    rcs_state_e       state_q, state_d;
    logic [CNT_W-1:0] last_cnt;
    logic             expired;

    // Pick the cycle limit that applies to the current state.
    always_comb begin
        unique case (state_q)
            ST_HOLD:   last_cnt = PERST_LAST;
            ST_SETTLE: last_cnt = SETTLE_LAST;
            ST_POLL:   last_cnt = READY_LAST;
            default:   last_cnt = HS_LAST;
        endcase
        expired = (count_i == last_cnt);
    end

    // Next-state decision from inputs and the shared timer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAIL: if (start_i) state_d = ST_PHY;
            ST_PHY:    if (phy_ok_i) state_d = ST_REQ0;
                       else if (expired) state_d = ST_FAIL;
            ST_REQ0:   if (ack0_i) state_d = ST_REQ1;
                       else if (expired) state_d = ST_FAIL;
            ST_REQ1:   if (ack1_i) state_d = ST_HOLD;
                       else if (expired) state_d = ST_FAIL;
            ST_HOLD:   if (expired) state_d = ST_SETTLE;
            ST_SETTLE: if (expired) state_d = ST_POLL;
            ST_POLL:   if (ready_i) state_d = ST_KICK;
                       else if (expired) state_d = ST_FAIL;
            ST_KICK:   state_d = ST_DONE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr_o = (state_d != state_q);

    // State register and the output actions tied to each entered state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            app_en_o   <= 1'b0;
            cfg_o      <= 1'b0;
            req0_o     <= 1'b0;
            req1_o     <= 1'b0;
            lane_en_o  <= 2'b00;
            port_en_o  <= 1'b0;
            gate_dis_o <= 1'b1;
            perst_n_o  <= 1'b0;
            kick_o     <= 1'b0;
            done_o     <= 1'b0;
            fail_o     <= 1'b0;
        end else begin
            state_q <= state_d;
            kick_o  <= 1'b0;
            if (state_d != state_q) begin
                unique case (state_d)
                    ST_PHY: begin
                        app_en_o   <= 1'b1;
                        cfg_o      <= 1'b0;
                        req0_o     <= 1'b0;
                        req1_o     <= 1'b0;
                        lane_en_o  <= 2'b00;
                        port_en_o  <= 1'b0;
                        gate_dis_o <= 1'b1;
                        perst_n_o  <= 1'b0;
                        done_o     <= 1'b0;
                        fail_o     <= 1'b0;
                    end
                    ST_REQ0: begin
                        cfg_o  <= 1'b1;
                        req0_o <= 1'b1;
                    end
                    ST_REQ1:   req1_o <= 1'b1;
                    ST_HOLD: begin
                        cfg_o     <= 1'b0;
                        lane_en_o <= 2'b11;
                        port_en_o <= 1'b1;
                    end
                    ST_SETTLE: perst_n_o  <= 1'b1;
                    ST_KICK:   gate_dis_o <= 1'b0;
                    ST_DONE: begin
                        kick_o <= 1'b1;
                        done_o <= 1'b1;
                    end
                    ST_FAIL: begin
                        cfg_o  <= 1'b0;
                        fail_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/refclk_bringup_seq.sv
// Top of the reference-clock bring-up sequencer. Converts the microsecond
// parameters into cycle limits, sizes the shared timer, and ties the timer to
// the control FSM. Assumes all inputs are synchronous to clk.
module refclk_bringup_seq
    import rcs_pkg::*;
#(
    parameter int unsigned CLK_KHZ   = 24000,
    parameter int unsigned HS_US     = 50000,
    parameter int unsigned PERST_US  = 100,
    parameter int unsigned SETTLE_US = 100000,
    parameter int unsigned READY_US  = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       phy_refclk_ok_i,
    input  logic       lane_ack0_i,
    input  logic       lane_ack1_i,
    input  logic       port_ready_i,
    output logic       app_clk_en_o,
    output logic       cfg_access_o,
    output logic       lane_req0_o,
    output logic       lane_req1_o,
    output logic [1:0] lane_refclk_en_o,
    output logic       port_refclk_en_o,
    output logic       refclk_gate_dis_o,
    output logic       appclk_gate_dis_o,
    output logic       perst_n_o,
    output logic       ltssm_start_o,
    output logic       done_o,
    output logic       timeout_o
);

    localparam int unsigned HS_CYC     = us_to_cyc(CLK_KHZ, HS_US);
    localparam int unsigned PERST_CYC  = us_to_cyc(CLK_KHZ, PERST_US);
    localparam int unsigned SETTLE_CYC = us_to_cyc(CLK_KHZ, SETTLE_US);
    localparam int unsigned READY_CYC  = us_to_cyc(CLK_KHZ, READY_US);
    localparam int unsigned MAX_CYC    = max4(HS_CYC, PERST_CYC, SETTLE_CYC, READY_CYC);
    localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);

    logic             tmr_clr;
    logic [CNT_W-1:0] tmr_count;
    logic             gate_dis;

    rcs_cycle_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (tmr_clr),
        .count_o (tmr_count)
    );

    rcs_bringup_fsm #(
        .CNT_W      (CNT_W),
        .HS_CYC     (HS_CYC),
        .PERST_CYC  (PERST_CYC),
        .SETTLE_CYC (SETTLE_CYC),
        .READY_CYC  (READY_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .phy_ok_i   (phy_refclk_ok_i),
        .ack0_i     (lane_ack0_i),
        .ack1_i     (lane_ack1_i),
        .ready_i    (port_ready_i),
        .count_i    (tmr_count),
        .tmr_clr_o  (tmr_clr),
        .app_en_o   (app_clk_en_o),
        .cfg_o      (cfg_access_o),
        .req0_o     (lane_req0_o),
        .req1_o     (lane_req1_o),
        .lane_en_o  (lane_refclk_en_o),
        .port_en_o  (port_refclk_en_o),
        .gate_dis_o (gate_dis),
        .perst_n_o  (perst_n_o),
        .kick_o     (ltssm_start_o),
        .done_o     (done_o),
        .fail_o     (timeout_o)
    );

    assign refclk_gate_dis_o = gate_dis;
    assign appclk_gate_dis_o = gate_dis;

endmodule

// File: rtl/rcs_checker.sv
// Property checker for the bring-up sequencer, attached to every instance of
// the top through bind. Measures the clock-to-reset-release gap with its own counter.
module rcs_checker #(
    parameter int unsigned PERST_CYC = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       lane_ack0_i,
    input logic       cfg_access_o,
    input logic       lane_req0_o,
    input logic       lane_req1_o,
    input logic [1:0] lane_refclk_en_o,
    input logic       port_refclk_en_o,
    input logic       refclk_gate_dis_o,
    input logic       appclk_gate_dis_o,
    input logic       perst_n_o,
    input logic       ltssm_start_o,
    input logic       done_o,
    input logic       timeout_o
);

    logic [31:0] since_clk;

    // Count cycles with the port reference clock enabled, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || !port_refclk_en_o) since_clk <= '0;
        else if (since_clk != 32'hFFFF_FFFF) since_clk <= since_clk + 1;
    end

    a_r3_req0_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_req0_o) |-> cfg_access_o);

    a_r3_req1_after_ack0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_req1_o) |-> $past(lane_ack0_i));

    a_r4_window_closed: assert property (@(posedge clk) disable iff (!rst_n)
        port_refclk_en_o |-> (!cfg_access_o && lane_refclk_en_o == 2'b11));

    a_r5_perst_min_delay: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perst_n_o) |-> (since_clk >= PERST_CYC));

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_start_o |=> !ltssm_start_o);

    a_r7_ungated_first: assert property (@(posedge clk) disable iff (!rst_n)
        ltssm_start_o |-> (!refclk_gate_dis_o && !appclk_gate_dis_o && done_o && perst_n_o));

    a_r8_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o));

endmodule

bind refclk_bringup_seq rcs_checker #(.PERST_CYC(PERST_CYC)) u_rcs_checker (
    .clk               (clk),
    .rst_n             (rst_n),
    .lane_ack0_i       (lane_ack0_i),
    .cfg_access_o      (cfg_access_o),
    .lane_req0_o       (lane_req0_o),
    .lane_req1_o       (lane_req1_o),
    .lane_refclk_en_o  (lane_refclk_en_o),
    .port_refclk_en_o  (port_refclk_en_o),
    .refclk_gate_dis_o (refclk_gate_dis_o),
    .appclk_gate_dis_o (appclk_gate_dis_o),
    .perst_n_o         (perst_n_o),
    .ltssm_start_o     (ltssm_start_o),
    .done_o            (done_o),
    .timeout_o         (timeout_o)
);

// File: tb/test_refclk_bringup_seq.sv
// Scoreboard bench: the driver pushes expected output events with their cycle,
// the monitor pops and compares them as the outputs change.
module test_refclk_bringup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int KHZ = 1500;
    localparam int HS_US = 30, PERST_US = 7, SETTLE_US = 20, READY_US = 40;

    // R10: cycle counts computed independently as ceil(khz*us/1000), min 1.
    function automatic int cyc_of(input int us);
        int c;
        c = (KHZ * us + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction
    localparam int H = (KHZ * HS_US + 999) / 1000;
    localparam int P = (KHZ * PERST_US + 999) / 1000;
    localparam int S = (KHZ * SETTLE_US + 999) / 1000;
    localparam int R = (KHZ * READY_US + 999) / 1000;

    localparam int EV_APP = 1, EV_CFG_UP = 2, EV_REQ0 = 3, EV_REQ1 = 4, EV_CFG_DN = 5,
                   EV_CLKEN = 6, EV_PERST = 7, EV_UNGATE = 8, EV_LTSSM = 9,
                   EV_DONE = 10, EV_ERR = 11, EV_DONE_DN = 12, EV_ERR_DN = 13;

    typedef struct { int code; int cyc; string tag; } exp_t;
    exp_t exp_q[$];

    logic clk = 0, rst_n = 0, start = 0, phy = 0, ack0 = 0, ack1 = 0, ready = 0;
    logic app, cfg, req0, req1, port_en, gate_r, gate_a, perst_n, ltssm, done, tmo;
    logic [1:0] lane_en;
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit mon_on = 0, finished = 0;

    refclk_bringup_seq #(.CLK_KHZ(KHZ), .HS_US(HS_US), .PERST_US(PERST_US),
                         .SETTLE_US(SETTLE_US), .READY_US(READY_US)) i_refclk_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .phy_refclk_ok_i(phy),
        .lane_ack0_i(ack0), .lane_ack1_i(ack1), .port_ready_i(ready),
        .app_clk_en_o(app), .cfg_access_o(cfg), .lane_req0_o(req0), .lane_req1_o(req1),
        .lane_refclk_en_o(lane_en), .port_refclk_en_o(port_en),
        .refclk_gate_dis_o(gate_r), .appclk_gate_dis_o(gate_a), .perst_n_o(perst_n),
        .ltssm_start_o(ltssm), .done_o(done), .timeout_o(tmo));

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, expv, cyc);
        end
    endtask

    task automatic expect_ev(input int code, input int at, input string tag);
        exp_t e;
        e.code = code; e.cyc = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic observe(input int code);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(0, "R9", "unexpected event code", code, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.code == code, e.tag, "event code", code, e.code);
            check(e.cyc == cyc, e.tag, "event cycle", cyc, e.cyc);
        end
    endtask

    // Monitor: turn output edges into events, in a fixed order per cycle.
    logic p_app, p_cfg, p_req0, p_req1, p_port, p_gate, p_perst, p_ltssm, p_done, p_tmo;
    always @(negedge clk) begin
        if (mon_on) begin
            if (app && !p_app) observe(EV_APP);
            if (cfg && !p_cfg) observe(EV_CFG_UP);
            if (req0 && !p_req0) observe(EV_REQ0);
            if (req1 && !p_req1) observe(EV_REQ1);
            if (!cfg && p_cfg) observe(EV_CFG_DN);
            if (port_en && !p_port) begin
                observe(EV_CLKEN);
                check(lane_en == 2'b11, "R4", "lane enables", lane_en, 3);
            end
            if (perst_n && !p_perst) observe(EV_PERST);
            if (!gate_r && p_gate) begin
                observe(EV_UNGATE);
                check(gate_a == 1'b0, "R7", "app gating disable", gate_a, 0);
            end
            if (ltssm && !p_ltssm) observe(EV_LTSSM);
            if (done && !p_done) observe(EV_DONE);
            if (tmo && !p_tmo) observe(EV_ERR);
            if (!done && p_done) observe(EV_DONE_DN);
            if (!tmo && p_tmo) observe(EV_ERR_DN);
        end
        p_app = app; p_cfg = cfg; p_req0 = req0; p_req1 = req1; p_port = port_en;
        p_gate = gate_r; p_perst = perst_n; p_ltssm = ltssm; p_done = done; p_tmo = tmo;
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic pulse_start(output int s);
        @(negedge clk);
        start = 1; s = cyc;
        @(negedge clk);
        start = 0;
    endtask

    initial begin : driver
        int s, a, b, q;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(app == 0 && cfg == 0 && req0 == 0 && req1 == 0, "R1", "enables/requests low", app, 0);
        check(lane_en == 0 && port_en == 0, "R1", "clock enables low", port_en, 0);
        check(gate_r == 1 && gate_a == 1, "R1", "gating disables high", gate_r, 1);
        check(perst_n == 0 && ltssm == 0 && done == 0 && tmo == 0, "R1", "reset/flags low", perst_n, 0);
        check(H == cyc_of(HS_US) && P == 11 && S == 30 && R == 60, "R10", "derived cycles", P, 11);
        rst_n = 1; mon_on = 1;

        // T1 nominal, ready already high during settle (R2 R3 R4 R5 R6 R7), busy start (R9)
        phy = 1; ready = 1;
        pulse_start(s);
        expect_ev(EV_APP, s + 1, "R2");
        expect_ev(EV_CFG_UP, s + 2, "R3");
        expect_ev(EV_REQ0, s + 2, "R3");
        wait_until(s + 5);
        ack0 = 1; a = cyc;
        expect_ev(EV_REQ1, a + 1, "R3");
        wait_until(a + 3);
        ack1 = 1; b = cyc;
        expect_ev(EV_CFG_DN, b + 1, "R4");
        expect_ev(EV_CLKEN, b + 1, "R4");
        expect_ev(EV_PERST, b + 1 + P, "R5");
        expect_ev(EV_UNGATE, b + 2 + P + S, "R6");
        expect_ev(EV_LTSSM, b + 3 + P + S, "R7");
        expect_ev(EV_DONE, b + 3 + P + S, "R7");
        wait_until(b + 1 + P + 5);
        pulse_start(q);  // R9: ignored mid-sequence
        wait_until(b + 4 + P + S);
        check(ltssm == 0, "R7", "start pulse width", ltssm, 0);
        check(done == 1 && tmo == 0, "R8", "done sticky", done, 1);
        ack0 = 0; ack1 = 0;
        wait_until(cyc + 5);
        check(done == 1, "R8", "done held", done, 1);

        // T2 restart from done; PHY status never arrives (R2 R8)
        phy = 0;
        pulse_start(s);
        expect_ev(EV_DONE_DN, s + 1, "R8");
        expect_ev(EV_ERR, s + 1 + H, "R2");
        wait_until(s + 2);
        check(port_en == 0 && lane_en == 0 && perst_n == 0 && gate_r == 1, "R8", "restart clears", port_en, 0);
        check(req0 == 0 && cfg == 0, "R2", "no request before PHY", req0, 0);
        wait_until(s + 6 + H);
        check(tmo == 1 && done == 0, "R8", "timeout sticky", tmo, 1);

        // T3 late PHY status, acknowledge 0 missing (R3)
        pulse_start(s);
        expect_ev(EV_ERR_DN, s + 1, "R8");
        wait_until(s + 6);
        phy = 1; q = cyc;
        expect_ev(EV_CFG_UP, q + 1, "R3");
        expect_ev(EV_REQ0, q + 1, "R3");
        expect_ev(EV_CFG_DN, q + 1 + H, "R3");
        expect_ev(EV_ERR, q + 1 + H, "R3");
        wait_until(q + 4 + H);
        check(req1 == 0, "R3", "request 1 without ack 0", req1, 0);

        // T4 acknowledge 0 present on entry, acknowledge 1 missing (R3)
        ack0 = 1;
        pulse_start(s);
        expect_ev(EV_ERR_DN, s + 1, "R8");
        expect_ev(EV_CFG_UP, s + 2, "R3");
        expect_ev(EV_REQ0, s + 2, "R3");
        expect_ev(EV_REQ1, s + 3, "R3");
        expect_ev(EV_CFG_DN, s + 3 + H, "R3");
        expect_ev(EV_ERR, s + 3 + H, "R3");
        wait_until(s + 6 + H);
        check(port_en == 0, "R3", "no clock after failed handshake", port_en, 0);

        // T5 port ready never comes (R6)
        ack1 = 1; ready = 0;
        pulse_start(s);
        expect_ev(EV_ERR_DN, s + 1, "R8");
        expect_ev(EV_CFG_UP, s + 2, "R3");
        expect_ev(EV_REQ0, s + 2, "R3");
        expect_ev(EV_REQ1, s + 3, "R3");
        expect_ev(EV_CFG_DN, s + 4, "R4");
        expect_ev(EV_CLKEN, s + 4, "R4");
        expect_ev(EV_PERST, s + 4 + P, "R5");
        expect_ev(EV_ERR, s + 4 + P + S + R, "R6");
        wait_until(s + 7 + P + S + R);
        check(gate_r == 1 && ltssm == 0 && done == 0, "R6", "no ungate on timeout", gate_r, 1);

        // T6 port ready arrives late in the poll window (R6 R7)
        pulse_start(s);
        expect_ev(EV_ERR_DN, s + 1, "R8");
        expect_ev(EV_CFG_UP, s + 2, "R3");
        expect_ev(EV_REQ0, s + 2, "R3");
        expect_ev(EV_REQ1, s + 3, "R3");
        expect_ev(EV_CFG_DN, s + 4, "R4");
        expect_ev(EV_CLKEN, s + 4, "R4");
        expect_ev(EV_PERST, s + 4 + P, "R5");
        wait_until(s + 4 + P + S + 10);
        ready = 1; q = cyc;
        expect_ev(EV_UNGATE, q + 1, "R6");
        expect_ev(EV_LTSSM, q + 2, "R7");
        expect_ev(EV_DONE, q + 2, "R7");
        wait_until(q + 6);
        check(ltssm == 0 && done == 1, "R7", "single start pulse", ltssm, 0);
        check(exp_q.size() == 0, "R9", "events still pending", exp_q.size(), 0);
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog: actual %0d expected %0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule